// File: doc/BRIEF.md
# Video Line Delay Buffer Controller

This block sits on a raster pixel stream qualified by a frame-active and a line-active signal. Every active line is stored in an on-chip buffer one line deep. While the next line arrives, the stored line is played back column by column. Downstream logic therefore sees two pixels in the same cycle: the live pixel, and the pixel directly above it from the previous captured line.

Reads begin on the same line-start edge as writes. They are held back only until the buffer has received its first line, so the number of pixels read always trails the number written by exactly one line. After any reset, capture waits until the frame-active input has been seen low. Storing therefore always begins at the top line of a frame, even when reset is released in the middle of a running frame.

When no genuine line-above pixel exists, the upper output carries a fixed alternating-bit fill pattern. A flag marks the first line of each frame, because on that line the upper pixel comes from the bottom line of the previous frame.

Top module: `video_line_delay`

## Requirements
- R1: While reset is asserted and right after it is released, above_vld and top_line are 0, cur_pix is 0 and above_pix carries the fill pattern (0xAA at PIX_W = 8).
- R2: After reset, no line is captured or played back until frame_vld has been sampled low in at least one cycle. Lines that arrive earlier produce no above_vld and no top_line.
- R3: A line is captured only if frame_vld is high at the cycle where line_vld rises. Pixels presented while frame_vld is low are never stored.
- R4: The first line captured after reset is stored without playback: above_vld stays 0 throughout that line.
- R5: Every later captured line is played back from its first pixel. above_vld is 1 for each of its pixels, and above_pix equals the pixel at the same column of the previously captured line, including across frame boundaries.
- R6: cur_pix equals pix_in delayed by exactly one clock, which aligns it with above_pix.
- R7: Whenever above_vld is 0, above_pix carries the fill pattern: alternating bits with the most significant bit set.
- R8: top_line is 1, aligned with cur_pix, for the pixels of the first captured line after frame_vld was low, and 0 otherwise.
- R9: Lines of any length from 1 to LINE_DEPTH pixels, all of equal length, are delayed without loss, including a length of exactly LINE_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released after two clock edges |
| frame_vld | input | 1 | High while a frame is active |
| line_vld | input | 1 | High while a line's pixels are presented |
| pix_in | input | PIX_W | Live pixel |
| cur_pix | output | PIX_W | Live pixel delayed one clock |
| above_pix | output | PIX_W | Pixel one line above cur_pix, or the fill pattern |
| above_vld | output | 1 | above_pix holds a stored pixel |
| top_line | output | 1 | Current pixel belongs to the first captured line of a frame |

## Verification
A wrong enable or pointer state shows at the ports within one line. A missing or extra read shifts every later above_pix by whole columns or lines. A wrongly set start-up or non-empty flag raises above_vld on a line that must show the fill pattern. The bench therefore sweeps every line length from 1 to the buffer depth, runs two frames after a reset taken mid-frame, and compares every output pixel of every cycle against a column model. Each error then appears at the first pixel it corrupts.

// File: rtl/vlb_pkg.sv
package vlb_pkg;
  typedef struct packed {
    logic wr;
    logic rd;
    logic first;
  } vlb_ctl_t;
endpackage

// File: rtl/vlb_rst_sync.sv
module vlb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok_n = sync_q[STAGES-1];
endmodule

// File: rtl/vlb_line_ctrl.sv
module vlb_line_ctrl
  import vlb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ok_n,
  input  logic     frame_vld,
  input  logic     line_vld,
  output vlb_ctl_t ctl
);
  logic armed_q, armed_d;
  logic lv_q;
  logic wr_run_q, rd_run_q;
  logic filled_q, filled_d;
  logic sof_q, sof_d;
  logic line_rise, wr_en, rd_en;

  always_comb begin
    line_rise = line_vld & ~lv_q;
    wr_en     = line_vld & frame_vld & armed_q & (line_rise | wr_run_q);
    rd_en     = wr_en & (line_rise ? filled_q : rd_run_q);
    armed_d   = armed_q | ~frame_vld;
    filled_d  = filled_q | wr_en;
    if (!frame_vld)           sof_d = 1'b1;
    else if (wr_run_q & ~wr_en) sof_d = 1'b0;
    else                      sof_d = sof_q;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      armed_q  <= 1'b0;
      lv_q     <= 1'b0;
      wr_run_q <= 1'b0;
      rd_run_q <= 1'b0;
      filled_q <= 1'b0;
      sof_q    <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      lv_q     <= line_vld;
      wr_run_q <= wr_en;
      rd_run_q <= rd_en;
      filled_q <= filled_d;
      sof_q    <= sof_d;
    end
  end

  assign ctl.wr    = wr_en;
  assign ctl.rd    = rd_en;
  assign ctl.first = wr_en & sof_q;
endmodule

// File: rtl/vlb_line_fifo.sv
module vlb_line_fifo #(
  parameter int PIX_W      = 8,
  parameter int LINE_DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst_ok_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [PIX_W-1:0] wr_data,
  output logic [PIX_W-1:0] rd_data
);
  localparam int ADDR_W = (LINE_DEPTH > 1) ? $clog2(LINE_DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LINE_DEPTH - 1);

  logic [PIX_W-1:0]  mem [LINE_DEPTH];
  logic [ADDR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (wr_en) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (rd_en) rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  // read returns the old word when both pointers meet
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_data;
    if (rd_en) rd_data <= mem[rd_ptr_q];
  end
endmodule

// File: rtl/video_line_delay.sv
module video_line_delay
  import vlb_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int LINE_DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_vld,
  input  logic             line_vld,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] cur_pix,
  output logic [PIX_W-1:0] above_pix,
  output logic             above_vld,
  output logic             top_line
);
  localparam logic [2*PIX_W-1:0] FILL_WIDE = {PIX_W{2'b10}};
  localparam logic [PIX_W-1:0]   FILL      = FILL_WIDE[PIX_W-1:0];

  logic             rst_ok_n;
  vlb_ctl_t         ctl;
  logic             wr_en, rd_en;
  logic [PIX_W-1:0] fifo_q;
  logic [PIX_W-1:0] cur_q;
  logic             vld_q, top_q;

  vlb_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ok_n (rst_ok_n)
  );

  vlb_line_ctrl u_ctrl (
    .clk       (clk),
    .rst_ok_n  (rst_ok_n),
    .frame_vld (frame_vld),
    .line_vld  (line_vld),
    .ctl       (ctl)
  );

  assign wr_en = ctl.wr;
  assign rd_en = ctl.rd;

  vlb_line_fifo #(.PIX_W(PIX_W), .LINE_DEPTH(LINE_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_ok_n (rst_ok_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_data  (pix_in),
    .rd_data  (fifo_q)
  );

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      cur_q <= '0;
      vld_q <= 1'b0;
      top_q <= 1'b0;
    end else begin
      cur_q <= pix_in;
      vld_q <= rd_en;
      top_q <= ctl.first;
    end
  end

  assign cur_pix   = cur_q;
  assign above_vld = vld_q;
  assign above_pix = vld_q ? fifo_q : FILL;
  assign top_line  = top_q;
endmodule

// File: rtl/video_line_delay_chk.sv
module video_line_delay_chk #(
  parameter int PIX_W      = 8,
  parameter int LINE_DEPTH = 1024
) (
  input logic             clk,
  input logic             rst_ok_n,
  input logic             frame_vld,
  input logic [PIX_W-1:0] pix_in,
  input logic             wr_en,
  input logic             rd_en,
  input logic             above_vld,
  input logic [PIX_W-1:0] cur_pix
);
  localparam int OCC_W = $clog2(LINE_DEPTH + 1);

  logic [OCC_W-1:0] occ_q;
  logic             seen_low_q;

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      occ_q      <= '0;
      seen_low_q <= 1'b0;
    end else begin
      occ_q      <= occ_q + OCC_W'(wr_en) - OCC_W'(rd_en);
      seen_low_q <= seen_low_q | ~frame_vld;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wr_en && !rd_en) |-> (occ_q < OCC_W'(LINE_DEPTH))); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rd_en |-> (occ_q != '0)); // R5
  AST_ARMED_FIRST: assert property (@(posedge clk) disable iff (!rst_ok_n)
    wr_en |-> seen_low_q); // R2
  AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_ok_n)
    wr_en |-> frame_vld); // R3
  AST_VLD_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    above_vld |-> $past(rd_en)); // R5
  AST_CUR_ALIGN: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rst_ok_n |=> (cur_pix == $past(pix_in))); // R6
endmodule

bind video_line_delay video_line_delay_chk #(.PIX_W(PIX_W), .LINE_DEPTH(LINE_DEPTH)) u_chk (
  .clk       (clk),
  .rst_ok_n  (rst_ok_n),
  .frame_vld (frame_vld),
  .pix_in    (pix_in),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .above_vld (above_vld),
  .cur_pix   (cur_pix)
);

// File: tb/video_line_delay_tb.sv
module video_line_delay_tb;
  localparam int DEPTH = 8;
  localparam logic [7:0] FILL = 8'hAA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_vld = 1'b1;
  logic line_vld = 1'b0;
  logic [7:0] pix_in = '0;
  logic [7:0] cur_pix, above_pix;
  logic above_vld, top_line;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  video_line_delay #(.PIX_W(8), .LINE_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .line_vld(line_vld),
    .pix_in(pix_in), .cur_pix(cur_pix), .above_pix(above_pix),
    .above_vld(above_vld), .top_line(top_line)
  );

  // column model
  logic armed, has, sof, wr_prev, rd_run, lv_prev;
  int col;
  int cur_len;
  logic [7:0] prev_line [DEPTH];
  logic [7:0] this_line [DEPTH];
  logic exp_on;
  logic [7:0] e_cur, e_above;
  logic e_vld, e_top;
  string e_tag;

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    armed = 0; has = 0; sof = 0; wr_prev = 0; rd_run = 0; lv_prev = 0; col = 0; exp_on = 0;
  endtask

  task automatic step(input logic f, input logic l, input logic [7:0] p);
    logic start, wr, rd;
    @(negedge clk);
    if (exp_on) begin
      chk("R6", "cur_pix", cur_pix, e_cur);
      chk(e_tag, "above_vld", {7'd0, above_vld}, {7'd0, e_vld});
      chk(e_vld ? e_tag : "R7", "above_pix", above_pix, e_above);
      chk("R8", "top_line", {7'd0, top_line}, {7'd0, e_top});
    end
    frame_vld = f; line_vld = l; pix_in = p;
    start = l && !lv_prev;
    wr = l && f && armed && (start || wr_prev);
    rd = wr && (start ? has : rd_run);
    e_cur = p;
    e_vld = rd;
    e_above = rd ? prev_line[col] : FILL;
    e_top = wr && sof;
    if (!armed) e_tag = "R2";
    else if (l && !f) e_tag = "R3";
    else if (rd) e_tag = (cur_len == DEPTH) ? "R9" : "R5";
    else if (wr) e_tag = "R4";
    else e_tag = "R7";
    if (wr) begin this_line[col] = p; col++; end
    if (wr_prev && !wr) begin
      for (int i = 0; i < DEPTH; i++) prev_line[i] = this_line[i];
      col = 0;
    end
    if (wr) has = 1;
    if (!f) sof = 1;
    else if (wr_prev && !wr) sof = 0;
    if (!f) armed = 1;
    rd_run = rd; wr_prev = wr; lv_prev = l;
    exp_on = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; frame_vld = 1; line_vld = 0; pix_in = 8'h5C;
    @(negedge clk);
    // R1 state while in reset
    chk("R1", "cur_pix", cur_pix, 8'h00);
    chk("R1", "above_pix", above_pix, FILL);
    chk("R1", "above_vld", {7'd0, above_vld}, 8'h00);
    chk("R1", "top_line", {7'd0, top_line}, 8'h00);
    pix_in = 8'h00;
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "above_pix after release", above_pix, FILL);
    chk("R1", "above_vld after release", {7'd0, above_vld}, 8'h00);
    model_reset();
  endtask

  task automatic line(input logic f, input int len, input int fr, input int ln);
    for (int c = 0; c < len; c++) step(f, 1'b1, 8'((fr << 6) + (ln << 3) + c + 1));
    step(f, 1'b0, 8'h00);
  endtask

  initial begin
    for (int len = 1; len <= DEPTH; len++) begin
      cur_len = len;
      do_reset();
      line(1'b1, len, 3, 7);          // mid-frame after reset: ignored (R2)
      step(1'b0, 1'b0, 8'h00);
      line(1'b0, len, 2, 6);          // line outside frame: ignored (R3)
      step(1'b0, 1'b0, 8'h00);
      step(1'b1, 1'b0, 8'h00);
      for (int ln = 0; ln < 3; ln++) line(1'b1, len, 0, ln); // R4, R5, R8
      step(1'b0, 1'b0, 8'h00);
      step(1'b0, 1'b0, 8'h00);
      step(1'b1, 1'b0, 8'h00);
      for (int ln = 0; ln < 2; ln++) line(1'b1, len, 1, ln); // wrap across frames
      step(1'b0, 1'b0, 8'h00);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule